// File: doc/BRIEF.md
# Dual-Port Mailbox Handshake Controller

This block holds the shared message memory between a host and an I/O coprocessor and watches the handshake traffic on it. There are seven channels. Each channel has one outgoing (send) message slot and one incoming (receive) message slot of 32 bytes, plus a state byte for each slot. Both sides read and write the same memory through two byte-wide ports. The host sends by filling a send slot and marking its state NEW. The coprocessor advances that state through RCVD to COMPLETE, and the host collects the reply from the same slot and returns the state to IDLE. On the receive side the roles are reversed: the coprocessor posts NEW, and the host acknowledges with RCVD and then COMPLETE. The coprocessor then returns the state to IDLE.

The block watches every write to a state byte. When a send state enters COMPLETE it raises a sticky host flag. When a receive state enters NEW it raises a second sticky host flag. Both flags drive one shared host interrupt line and two status bits that tell them apart. The host clears each flag on its own. A separate coprocessor interrupt is raised when the host kicks it and is dropped when the coprocessor acknowledges.

Top module: `mbox_ctrl`

## Requirements
- R1: After reset every send and receive state byte reads 0x00 (IDLE), both host status bits are 0, host_irq is 0 and cop_irq is 0.
- R2: The byte of message b (0..31) of channel c (0..6) is at address c*32+b for the send slots and at 224+c*32+b for the receive slots. A byte written through either port reads back on both ports in the cycle after the write, because the read data is combinational from the stored array. Writes to the message area never change the status bits.
- R3: The send state byte of channel c is at address 448+c and the receive state byte is at 455+c. Any 8-bit value written there reads back unchanged, and any address from 462 upward reads 0x00.
- R4: Status bit 0 is set in the cycle after a write that changes a send state byte from a value other than 0x03 to 0x03 (COMPLETE).
- R5: Status bit 1 is set in the cycle after a write that changes a receive state byte from a value other than 0x01 to 0x01 (NEW).
- R6: The state encodings are IDLE=0x00, NEW=0x01, RCVD=0x02 and COMPLETE=0x03. Writing any value above 0x03 is stored, but sets no status bit. Rewriting a state byte with the value it already holds sets no status bit.
- R7: Each status bit stays set until the host pulses irq_clr at that bit's position, even if the state changes again. If a set and a clear of the same bit fall in the same cycle, the bit stays set.
- R8: host_irq is high exactly when at least one status bit is set.
- R9: cop_irq is set in the cycle after h_kick and cleared in the cycle after c_ack. If both arrive in the same cycle, cop_irq is set.
- R10: If both ports write the same address in the same cycle, the host's data is stored, and only the host's write is evaluated for status bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| h_we | input | 1 | Host write strobe |
| h_addr | input | 9 | Host byte address |
| h_wdata | input | 8 | Host write data |
| h_rdata | output | 8 | Host read data (combinational) |
| c_we | input | 1 | Coprocessor write strobe |
| c_addr | input | 9 | Coprocessor byte address |
| c_wdata | input | 8 | Coprocessor write data |
| c_rdata | output | 8 | Coprocessor read data (combinational) |
| irq_clr | input | 2 | Host clear pulses for status bits 0 and 1 |
| h_kick | input | 1 | Host request to interrupt the coprocessor |
| c_ack | input | 1 | Coprocessor acknowledge of its interrupt |
| host_status | output | 2 | Bit 0: a send slot completed; bit 1: a receive slot got a new message |
| host_irq | output | 1 | Shared host interrupt line |
| cop_irq | output | 1 | Coprocessor interrupt |

## Verification
Some properties are checked on every cycle. The status bits can rise only after a write, and they stay set until cleared. The shared line always follows the status bits, a kick always raises the coprocessor interrupt, and an acknowledge without a kick drops it. Other behaviour depends on the previous contents of a state byte, so only the bench scenarios can show it. That covers the exact transition that counts as entering COMPLETE or NEW, rejection of invalid and repeated values, the address map of both slot regions, and which port wins an address collision.

// File: rtl/mbox_ctrl.sv
module mbox_ctrl #(
  parameter int NCHAN  = 7,
  parameter int MSGLEN = 32,
  localparam int BUFB  = NCHAN * MSGLEN,
  localparam int ST_S  = 2 * BUFB,
  localparam int ST_R  = ST_S + NCHAN,
  localparam int TOP   = ST_R + NCHAN,
  localparam int AW    = $clog2(TOP)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic [AW-1:0] h_addr,
  input  logic [7:0]    h_wdata,
  output logic [7:0]    h_rdata,
  input  logic          c_we,
  input  logic [AW-1:0] c_addr,
  input  logic [7:0]    c_wdata,
  output logic [7:0]    c_rdata,
  input  logic [1:0]    irq_clr,
  input  logic          h_kick,
  input  logic          c_ack,
  output logic [1:0]    host_status,
  output logic          host_irq,
  output logic          cop_irq
);
  localparam logic [7:0] ST_NEW  = 8'h01;
  localparam logic [7:0] ST_DONE = 8'h03;

  logic [7:0] msg_mem [ST_S];
  logic [7:0] snd_st  [NCHAN];
  logic [7:0] rcv_st  [NCHAN];
  logic [1:0] flags;
  logic       c_eff;
  logic [1:0] h_hit, c_hit;

  assign c_eff = c_we && !(h_we && h_addr == c_addr);

  function automatic logic [7:0] rd(input logic [AW-1:0] a);
    int ia;
    ia = int'(a);
    if (ia < ST_S)      return msg_mem[ia];
    else if (ia < ST_R) return snd_st[ia - ST_S];
    else if (ia < TOP)  return rcv_st[ia - ST_R];
    else                return 8'h00;
  endfunction

  function automatic logic [1:0] hit(input logic we, input logic [AW-1:0] a,
                                     input logic [7:0] d);
    int ia;
    ia = int'(a);
    hit = 2'b00;
    if (we && ia >= ST_S && ia < ST_R)
      hit[0] = (d == ST_DONE) && (snd_st[ia - ST_S] != ST_DONE);
    if (we && ia >= ST_R && ia < TOP)
      hit[1] = (d == ST_NEW) && (rcv_st[ia - ST_R] != ST_NEW);
  endfunction

  assign h_rdata = rd(h_addr);
  assign c_rdata = rd(c_addr);
  assign h_hit   = hit(h_we, h_addr, h_wdata);
  assign c_hit   = hit(c_eff, c_addr, c_wdata);

  always_ff @(posedge clk) begin
    if (c_eff && int'(c_addr) < ST_S) msg_mem[c_addr] <= c_wdata;
    if (h_we  && int'(h_addr) < ST_S) msg_mem[h_addr] <= h_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NCHAN; i++) begin
        snd_st[i] <= 8'h00;
        rcv_st[i] <= 8'h00;
      end
    end else begin
      for (int i = 0; i < NCHAN; i++) begin
        if (c_eff && int'(c_addr) == ST_S + i) snd_st[i] <= c_wdata;
        if (c_eff && int'(c_addr) == ST_R + i) rcv_st[i] <= c_wdata;
        if (h_we  && int'(h_addr) == ST_S + i) snd_st[i] <= h_wdata;
        if (h_we  && int'(h_addr) == ST_R + i) rcv_st[i] <= h_wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flags   <= 2'b00;
      cop_irq <= 1'b0;
    end else begin
      flags   <= h_hit | c_hit | (flags & ~irq_clr);
      cop_irq <= h_kick | (cop_irq & ~c_ack);
    end
  end

  assign host_status = flags;
  assign host_irq    = |flags;
endmodule

module mbox_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       h_we,
  input logic       c_we,
  input logic [1:0] irq_clr,
  input logic       h_kick,
  input logic       c_ack,
  input logic [1:0] host_status,
  input logic       host_irq,
  input logic       cop_irq
);
  p_send_flag_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_status[0]) |-> $past(h_we || c_we));
  p_recv_flag_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_status[1]) |-> $past(h_we || c_we));
  p_sticky0_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_status[0] && !irq_clr[0]) |=> host_status[0]);
  p_sticky1_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (host_status[1] && !irq_clr[1]) |=> host_status[1]);
  p_clear_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr == 2'b11 && !h_we && !c_we) |=> host_status == 2'b00);
  p_line_r8: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq == (host_status != 2'b00));
  p_kick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    h_kick |=> cop_irq);
  p_ack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (c_ack && !h_kick) |=> !cop_irq);
endmodule

bind mbox_ctrl mbox_ctrl_chk chk_i (.*);

// File: tb/mbox_ctrl_tb.sv
module mbox_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       h_we, c_we, h_kick, c_ack;
  logic [8:0] h_addr, c_addr;
  logic [7:0] h_wdata, c_wdata, h_rdata, c_rdata;
  logic [1:0] irq_clr, host_status;
  logic       host_irq, cop_irq;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  mbox_ctrl dut_i (.*);

  typedef struct packed {
    logic       cop;
    logic [8:0] addr;
    logic [7:0] data;
    logic [1:0] clr;
    logic [1:0] exp;
  } vec_t;

  localparam vec_t VEC [11] = '{
    '{1'b0, 9'd448, 8'h01, 2'b00, 2'b00},
    '{1'b1, 9'd448, 8'h02, 2'b00, 2'b00},
    '{1'b1, 9'd448, 8'h03, 2'b00, 2'b01},
    '{1'b1, 9'd448, 8'h03, 2'b01, 2'b00},
    '{1'b1, 9'd461, 8'h01, 2'b00, 2'b10},
    '{1'b1, 9'd455, 8'h07, 2'b00, 2'b10},
    '{1'b0, 9'd455, 8'h01, 2'b10, 2'b10},
    '{1'b0, 9'd454, 8'h03, 2'b10, 2'b01},
    '{1'b0, 9'd460, 8'h05, 2'b01, 2'b00},
    '{1'b1, 9'd460, 8'h01, 2'b00, 2'b10},
    '{1'b0, 9'd0,   8'h03, 2'b10, 2'b00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    h_we = 0; c_we = 0; irq_clr = 0; h_kick = 0; c_ack = 0;
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk); idle();
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    idle(); h_addr = 0; c_addr = 0; h_wdata = 0; c_wdata = 0; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1: reset state
    chk("R1 status", host_status, 2'b00);
    chk("R1 host_irq", host_irq, 0);
    chk("R1 cop_irq", cop_irq, 0);
    for (int i = 448; i < 462; i++) begin
      h_addr = 9'(i); #1;
      chk("R1 state idle", h_rdata, 8'h00);
    end

    // R4 R5 R6 R7 R8: vector walk
    for (int k = 0; k < 11; k++) begin
      if (VEC[k].cop) begin c_we = 1; c_addr = VEC[k].addr; c_wdata = VEC[k].data; end
      else begin h_we = 1; h_addr = VEC[k].addr; h_wdata = VEC[k].data; end
      irq_clr = VEC[k].clr;
      step();
      chk($sformatf("R4/R5/R6/R7 vec%0d", k), host_status, VEC[k].exp);
      chk("R8 line", host_irq, VEC[k].exp != 2'b00);
    end

    // R3: state readback and out-of-range
    h_addr = 9'd455; c_addr = 9'd460; #1;
    chk("R3 recv ch0", h_rdata, 8'h01);
    chk("R3 recv ch5", c_rdata, 8'h01);
    h_addr = 9'd448; c_addr = 9'd462; #1;
    chk("R3 send ch0", h_rdata, 8'h03);
    chk("R3 out of range", c_rdata, 8'h00);

    // R2: message regions through both ports
    irq_clr = 2'b11; step();
    h_we = 1; h_addr = 9'd223; h_wdata = 8'hA5;
    c_we = 1; c_addr = 9'd224 + 9'd6*9'd32 + 9'd31; c_wdata = 8'h3C;
    step();
    c_addr = 9'd223; h_addr = 9'd447; #1;
    chk("R2 send ch6 b31", c_rdata, 8'hA5);
    chk("R2 recv ch6 b31", h_rdata, 8'h3C);
    h_addr = 9'd0; #1;
    chk("R2 send ch0 b0", h_rdata, 8'h03);
    chk("R2 no flag", host_status, 2'b00);

    // R10: collision on a state byte
    h_we = 1; h_addr = 9'd449; h_wdata = 8'h02;
    c_we = 1; c_addr = 9'd449; c_wdata = 8'h03;
    step();
    h_addr = 9'd449; #1;
    chk("R10 host data kept", h_rdata, 8'h02);
    chk("R10 cop write ignored", host_status, 2'b00);
    h_we = 1; h_addr = 9'd10; h_wdata = 8'h11;
    c_we = 1; c_addr = 9'd10; c_wdata = 8'h22;
    step();
    h_addr = 9'd10; #1;
    chk("R10 message collision", h_rdata, 8'h11);

    // R9: coprocessor interrupt
    h_kick = 1; step();
    chk("R9 kick", cop_irq, 1);
    step();
    chk("R9 held", cop_irq, 1);
    h_kick = 1; c_ack = 1; step();
    chk("R9 kick wins", cop_irq, 1);
    c_ack = 1; step();
    chk("R9 ack", cop_irq, 0);

    // R1: reset returns states to IDLE
    rst_n = 0; step(); rst_n = 1;
    h_addr = 9'd448; c_addr = 9'd460; #1;
    chk("R1 rereset send", h_rdata, 8'h00);
    chk("R1 rereset recv", c_rdata, 8'h00);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule